// File: doc/BRIEF.md
# Shadowed Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, together with the current pixel column and line. The pixel fetch and output encoder logic that consumes these use them as their reference. Every coordinate counts from the leading edge of sync. A line runs through sync, back porch, the active pixels and front porch, in that order, and a frame is built from lines in the same way.

Software writes the timing words, the polarity group and the control bits into a pending register set through a simple write port. Nothing it writes there reaches the raster until it writes a commit. The pending set is then copied into the active set at the next frame boundary, so a frame is never produced with a mix of old and new timing. A standby control halts the raster and parks every output at its inactive level. One of four downstream interfaces can be enabled at a time.

Top module: `raster_timing_gen`

## Requirements
- R1: Register map on `wr_addr_i`, all in `wr_data_i`:
  - Address 1 is control: bits 3:0 are polarity, bit 4 is standby, bit 5 is output enable and bits 7:6 are the interface select.
  - Address 2 holds the horizontal period in clocks in bits 28:16 and the hsync length in bits 12:0.
  - Address 3 holds the horizontal active start in bits 28:16 and the active end in bits 12:0.
  - Addresses 4 and 5 are the vertical equivalents of 2 and 3.
  - Address 0 is the commit register.
- R2: While running, `x_o` counts 0 to period-1 and wraps. `y_o` advances once per line wrap and wraps after the vertical period. Both are aligned with the strobes, one clock after the internal counters.
- R3: The raw sync is active while the count is below the sync length, from count 0 up to but not including that length. This holds for both hsync and vsync.
- R4: The raw data enable is active only when both counts are at or above their active start and below their active end.
- R5: Polarity bit order is 3 pixel clock, 2 data enable, 1 vsync, 0 hsync. A strobe is driven inverted (active-low) when its bit is 0. `pclk_pol_o` carries bit 3.
- R6: Writes to addresses 1 to 5 without a commit have no effect on any output.
- R7: Writing 1 to bit 0 of address 0 latches a commit. The commit copies the pending set into the active set at the clock where the counters wrap from the last pixel of the frame to (0,0). The commit then clears itself, and later boundaries change nothing.
- R8: While standby is active, the counters hold at zero and the strobes sit at their inactive levels. `x_o`, `y_o` and `out_en_o` are zero. A commit issued in standby applies on the next clock. Leaving standby starts a frame at (0,0).
- R9: `out_en_o` is one-hot, with bit sel set, when output enable is 1 and standby is 0. Otherwise it is zero.
- R10: After reset, the pending and active sets are zero except standby = 1. `hsync_o`, `vsync_o` and `de_o` are 1, which is their inactive level for polarity 0. All other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pclk_pol_o | output | 1 | Pixel clock polarity selection |
| x_o | output | 13 | Pixel column from sync edge |
| y_o | output | 13 | Line from sync edge |
| out_en_o | output | 4 | One-hot interface enable |

## Verification
A fixed directed timing with every polarity bit set checks the basic sync widths and the active window. Randomized porches, sync lengths, active sizes, polarity groups and interface selects then separate errors in the compare bounds from errors in the period wrap. Commits are issued at random points inside a frame, and pending writes are left uncommitted for whole frames. Together these show whether new timing lands only at the frame wrap. A standby entry and exit pair shows that the outputs park at their inactive levels and that the raster restarts from (0,0).

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int TW     = 13;
  localparam int DW     = 32;
  localparam int AW     = 3;
  localparam int NIF    = 4;
  localparam int SELW   = $clog2(NIF);
  localparam int HI_LSB = 16;

  localparam logic [AW-1:0] ADR_CMT  = 3'd0;
  localparam logic [AW-1:0] ADR_CTL  = 3'd1;
  localparam logic [AW-1:0] ADR_HPER = 3'd2;
  localparam logic [AW-1:0] ADR_HACT = 3'd3;
  localparam logic [AW-1:0] ADR_VPER = 3'd4;
  localparam logic [AW-1:0] ADR_VACT = 3'd5;

  typedef struct packed {
    logic [TW-1:0] period;
    logic [TW-1:0] sync_len;
    logic [TW-1:0] act_st;
    logic [TW-1:0] act_end;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t       h;
    axis_cfg_t       v;
    logic [3:0]      pol;   // 3 pclk, 2 de, 1 vsync, 0 hsync
    logic            stby;
    logic            oe;
    logic [SELW-1:0] sel;
  } rtg_cfg_t;
endpackage

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  assign last_o = (cnt_o == period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (!run_i)  cnt_o <= '0;
    else if (step_i)  cnt_o <= last_o ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/rtg_shadow.sv
module rtg_shadow
  import rtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          frame_end_i,
  output rtg_cfg_t      act_o
);
  rtg_cfg_t pend_q;
  logic     cmt_q, apply;

  localparam rtg_cfg_t RST_CFG = '{stby: 1'b1, default: '0};

  wire cmt_wr = wr_en_i && (wr_addr_i == ADR_CMT) && wr_data_i[0];
  assign apply = cmt_q & frame_end_i;

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[DW-1:HI_LSB+TW], wr_data_i[HI_LSB-1:TW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_CFG;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADR_CTL: begin
          pend_q.pol  <= wr_data_i[3:0];
          pend_q.stby <= wr_data_i[4];
          pend_q.oe   <= wr_data_i[5];
          pend_q.sel  <= wr_data_i[6 +: SELW];
        end
        ADR_HPER: begin
          pend_q.h.period   <= wr_data_i[HI_LSB +: TW];
          pend_q.h.sync_len <= wr_data_i[0 +: TW];
        end
        ADR_HACT: begin
          pend_q.h.act_st  <= wr_data_i[HI_LSB +: TW];
          pend_q.h.act_end <= wr_data_i[0 +: TW];
        end
        ADR_VPER: begin
          pend_q.v.period   <= wr_data_i[HI_LSB +: TW];
          pend_q.v.sync_len <= wr_data_i[0 +: TW];
        end
        ADR_VACT: begin
          pend_q.v.act_st  <= wr_data_i[HI_LSB +: TW];
          pend_q.v.act_end <= wr_data_i[0 +: TW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= RST_CFG;
      cmt_q <= 1'b0;
    end else begin
      if (apply) act_o <= pend_q;
      cmt_q <= (cmt_q & ~apply) | cmt_wr;
    end
  end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [TW-1:0]  hc_i,
  input  logic [TW-1:0]  vc_i,
  input  rtg_cfg_t       cfg_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           pclk_pol_o,
  output logic [TW-1:0]  x_o,
  output logic [TW-1:0]  y_o,
  output logic [NIF-1:0] out_en_o
);
  logic [2:0]     raw, strb;
  logic [NIF-1:0] oe_dec;

  assign raw[0] = hc_i < cfg_i.h.sync_len;
  assign raw[1] = vc_i < cfg_i.v.sync_len;
  assign raw[2] = (hc_i >= cfg_i.h.act_st) && (hc_i < cfg_i.h.act_end) &&
                  (vc_i >= cfg_i.v.act_st) && (vc_i < cfg_i.v.act_end);
  // polarity 0 drives active-low; standby parks at the inactive level
  assign strb = run_i ? (raw ~^ cfg_i.pol[2:0]) : ~cfg_i.pol[2:0];

  for (genvar i = 0; i < NIF; i++) begin : g_oe
    assign oe_dec[i] = run_i && cfg_i.oe && (cfg_i.sel == SELW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {de_o, vsync_o, hsync_o} <= 3'b111;
      pclk_pol_o <= 1'b0;
      x_o        <= '0;
      y_o        <= '0;
      out_en_o   <= '0;
    end else begin
      {de_o, vsync_o, hsync_o} <= strb;
      pclk_pol_o <= cfg_i.pol[3];
      x_o        <= run_i ? hc_i : '0;
      y_o        <= run_i ? vc_i : '0;
      out_en_o   <= oe_dec;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_addr_i,
  input  logic [31:0]         wr_data_i,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic                pclk_pol_o,
  output logic [12:0]         x_o,
  output logic [12:0]         y_o,
  output logic [3:0]          out_en_o
);
  rtg_cfg_t      act_cfg;
  logic [TW-1:0] hc, vc;
  logic          h_last, v_last, run_w, frame_end_w;

  assign run_w       = ~act_cfg.stby;
  assign frame_end_w = ~run_w | (h_last & v_last);

  rtg_shadow u_shadow (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .frame_end_i(frame_end_w), .act_o(act_cfg)
  );

  rtg_counter #(.W(TW)) u_hcnt (
    .clk_i, .rst_ni, .run_i(run_w), .step_i(1'b1),
    .period_i(act_cfg.h.period), .cnt_o(hc), .last_o(h_last)
  );

  rtg_counter #(.W(TW)) u_vcnt (
    .clk_i, .rst_ni, .run_i(run_w), .step_i(h_last),
    .period_i(act_cfg.v.period), .cnt_o(vc), .last_o(v_last)
  );

  rtg_decode u_dec (
    .clk_i, .rst_ni, .run_i(run_w), .hc_i(hc), .vc_i(vc), .cfg_i(act_cfg),
    .hsync_o, .vsync_o, .de_o, .pclk_pol_o, .x_o, .y_o, .out_en_o
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           stby_i,
  input logic           frame_end_i,
  input rtg_cfg_t       cfg_i,
  input logic [TW-1:0]  x_o,
  input logic [TW-1:0]  y_o,
  input logic [NIF-1:0] out_en_o
);
  a_r2_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o != '0) |-> (x_o == $past(x_o) + 1'b1));

  a_r7_cfg_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_i) |-> $past(frame_end_i));

  a_r8_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (out_en_o == '0 && x_o == '0 && y_o == '0));

  a_r9_onehot_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_en_o));
endmodule

bind raster_timing_gen rtg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stby_i(act_cfg.stby),
  .frame_end_i(frame_end_w), .cfg_i(act_cfg),
  .x_o(x_o), .y_o(y_o), .out_en_o(out_en_o)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de, pclk_pol;
  logic [12:0] x, y;
  logic [3:0]  oe;

  always #4 clk = ~clk;

  raster_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .pclk_pol_o(pclk_pol), .x_o(x), .y_o(y), .out_en_o(oe)
  );

  int    n_chk = 0, n_fail = 0;
  string phase = "R10";

  // reference state: pending and active words, indexed by address
  logic [31:0] pw [1:5];
  logic [31:0] aw [1:5];
  logic        mcm = 1'b0;
  logic [12:0] mh = '0, mv = '0;
  logic        e_hs = 1'b1, e_vs = 1'b1, e_de = 1'b1, e_pc = 1'b0;
  logic [12:0] e_x = '0, e_y = '0;
  logic [3:0]  e_oe = '0;
  logic        e_stby = 1'b1;

  task automatic model_step();
    logic [3:0]  pol;
    logic [12:0] ht, hsl, hst, hen, vt, vsl, vst, ven;
    logic        stby, hl, fe, apply;
    logic [2:0]  raw;
    pol = aw[1][3:0]; stby = aw[1][4];
    ht = aw[2][28:16]; hsl = aw[2][12:0]; hst = aw[3][28:16]; hen = aw[3][12:0];
    vt = aw[4][28:16]; vsl = aw[4][12:0]; vst = aw[5][28:16]; ven = aw[5][12:0];
    e_stby = stby;
    e_pc = pol[3];
    if (stby) begin
      {e_de, e_vs, e_hs} = ~pol[2:0];
      e_x = '0; e_y = '0; e_oe = '0;
    end else begin
      raw[0] = mh < hsl;
      raw[1] = mv < vsl;
      raw[2] = (mh >= hst) && (mh < hen) && (mv >= vst) && (mv < ven);
      {e_de, e_vs, e_hs} = raw ~^ pol[2:0];
      e_x = mh; e_y = mv;
      e_oe = aw[1][5] ? (4'b1 << aw[1][7:6]) : 4'b0;
    end
    hl = (mh == ht - 13'd1);
    fe = stby || (hl && mv == vt - 13'd1);
    if (stby) begin mh = '0; mv = '0; end
    else begin
      mh = hl ? 13'd0 : mh + 13'd1;
      if (hl) mv = (mv == vt - 13'd1) ? 13'd0 : mv + 13'd1;
    end
    apply = mcm & fe;
    if (apply) for (int i = 1; i <= 5; i++) aw[i] = pw[i];
    mcm = (mcm & ~apply) | (wr_en && wr_addr == 3'd0 && wr_data[0]);
    if (wr_en && wr_addr >= 3'd1 && wr_addr <= 3'd5) pw[wr_addr] = wr_data;
  endtask

  task automatic chk(string req, string nm, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s phase=%s actual=%0h expected=%0h", req, nm, phase, a, e);
    end
  endtask

  task automatic compare();
    chk("R3 R5", "hsync", hsync, e_hs);
    chk("R3 R5", "vsync", vsync, e_vs);
    chk("R4 R5", "de", de, e_de);
    chk("R5", "pclk_pol", pclk_pol, e_pc);
    chk(e_stby ? "R8" : "R2", "x", x, e_x);
    chk(e_stby ? "R8" : "R2", "y", y, e_y);
    chk("R9", "out_en", oe, e_oe);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // word packing per R1: high field 28:16, low field 12:0
  function automatic logic [31:0] pk(int hi, int lo);
    return {3'b0, 13'(hi), 3'b0, 13'(lo)};
  endfunction

  task automatic load(int hs, int hbp, int ha, int hfp, int vs, int vbp, int va,
                      int vfp, logic [3:0] pol, logic en, logic [1:0] sel, logic sb);
    wr(3'd1, {24'b0, sel, en, sb, pol});
    wr(3'd2, pk(hs + hbp + ha + hfp, hs));
    wr(3'd3, pk(hs + hbp, hs + hbp + ha));
    wr(3'd4, pk(vs + vbp + va + vfp, vs));
    wr(3'd5, pk(vs + vbp, vs + vbp + va));
  endtask

  initial begin
    for (int i = 1; i <= 5; i++) begin pw[i] = '0; aw[i] = '0; end
    pw[1] = 32'h10; aw[1] = 32'h10;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    phase = "R10";
    compare();
    rst_n = 1'b1;
    idle(5);

    phase = "R1";
    load(3, 2, 8, 3, 2, 1, 4, 2, 4'hF, 1'b1, 2'd2, 1'b0);
    idle(20);
    phase = "R7";
    wr(3'd0, 32'h1);
    idle(16 * 9 * 3);

    phase = "R6";
    load(2, 3, 10, 1, 1, 2, 5, 1, 4'h0, 1'b1, 2'd0, 1'b0);
    idle(16 * 9 * 2 + 7);
    phase = "R7";
    wr(3'd0, 32'h1);
    idle(16 * 9 + 16 * 10 * 3);

    for (int k = 0; k < 14; k++) begin
      phase = "R7";
      load($urandom_range(1, 8), $urandom_range(1, 8), $urandom_range(4, 32),
           $urandom_range(1, 8), $urandom_range(1, 4), $urandom_range(1, 4),
           $urandom_range(2, 16), $urandom_range(1, 4), 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b0);
      idle($urandom_range(0, 200));
      wr(3'd0, 32'h1);
      idle($urandom_range(1600, 3400));
    end

    phase = "R8";
    wr(3'd1, 32'h0000_0035);
    wr(3'd0, 32'h1);
    idle(2000);
    load(4, 1, 6, 2, 1, 1, 3, 1, 4'h5, 1'b1, 2'd1, 1'b0);
    wr(3'd0, 32'h1);
    idle(600);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired phase=%s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule